// File: doc/BRIEF.md
# Multiplexed hex display driver

This block shows a 16-bit value as four hexadecimal characters on a four-digit, common-anode seven-segment display. The display shares one set of segment lines among all four digits, so the block lights one digit at a time and rotates through them quickly enough that the eye sees a steady four-character readout.

A free-running counter on the master clock divides it down to a scan tick. The tick comes from one counter bit, and a parameter chooses which bit. Each rising edge of that bit advances a two-bit digit index. The index selects one nibble of the input, decodes it to a segment pattern and pulls one anode line low. An optional mode blanks leading zeros and always keeps the rightmost digit visible. An asynchronous active-high clear returns the counter and the digit index to zero.

Top module: `hexscan_top`

## Requirements
- R1: While `clr` is high, the divider count and the digit index are zero without waiting for a clock edge, so `an_n` reads 4'b1110 and `seg_n` shows nibble `value[3:0]`.
- R2: The digit index starts at 0 after clear and steps 0,1,2,3,0,… once per 2^(TAP+1) master clocks. Each step falls on the rising edge of counter bit TAP, so the first step comes 2^TAP clocks after clear is released. The default TAP is 17, about 190.7 Hz of steps from 50 MHz.
- R3: Exactly one anode line is low at any time. When the digit index is i, `an_n[i]` is low and the digit shows `value[4i+3:4i]`. Index 0 is the rightmost digit.
- R4: Segments are active-low, with `seg_n[6]`=a through `seg_n[0]`=g. As active-high abcdefg codes, nibbles 0..F light 7E,30,6D,79,33,5B,5F,70,7F,7B,77,1F,4E,3D,4F,47, which are the shapes 0-9, A, b, C, d, E, F.
- R5: `dp_n` is always 1, so the decimal point is off.
- R6: With `blank_en` low, every digit shows its nibble, leading zeros included.
- R7: With `blank_en` high, each zero nibble to the left of the most significant nonzero nibble is blank, meaning `seg_n`=7'h7F. Zeros to the right of that nibble are still shown.
- R8: Digit 0 is never blank. A zero value with blanking on shows a single 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Master clock |
| clr | input | 1 | Asynchronous clear, active high |
| value | input | 16 | Value to display, four hex nibbles |
| blank_en | input | 1 | Leading-zero blanking enable |
| seg_n | output | 7 | Segment lines a..g, active low |
| an_n | output | 4 | Digit anode enables, active low |
| dp_n | output | 1 | Decimal point, held high (off) |

## Verification
The bench uses a short tap, so a full rotation takes tens of clocks. It predicts the digit index from the number of clocks since clear and checks every cycle. An off-by-one tap or a step on the wrong edge would move the anode change by one or more cycles and break the scan order. Nibbles that include 0, a zero inside a number and every letter shape catch a wrong pattern or a wrong nibble slice. Values such as 0040, 0807 and 0000 with blanking on catch three errors: blanking that does not stop at the first nonzero nibble, blanking of interior zeros, and a dark display for a zero value. A clear raised in mid-cycle checks that the reset takes effect at once.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;
  localparam int DIGITS = 4;
  localparam int NIB_W  = 4;
  localparam int VAL_W  = DIGITS * NIB_W;
  localparam int IDX_W  = $clog2(DIGITS);
  localparam int SEG_W  = 7;
  localparam logic [SEG_W-1:0] SEG_DARK = '1;

  // Active-low segment pattern, bit 6 = a ... bit 0 = g.
  function automatic logic [SEG_W-1:0] nib_to_seg_n(input logic [NIB_W-1:0] n);
    logic [SEG_W-1:0] s;
    unique case (n)
      4'h0: s = 7'h01;
      4'h1: s = 7'h4F;
      4'h2: s = 7'h12;
      4'h3: s = 7'h06;
      4'h4: s = 7'h4C;
      4'h5: s = 7'h24;
      4'h6: s = 7'h20;
      4'h7: s = 7'h0F;
      4'h8: s = 7'h00;
      4'h9: s = 7'h04;
      4'hA: s = 7'h08;
      4'hB: s = 7'h60;
      4'hC: s = 7'h31;
      4'hD: s = 7'h42;
      4'hE: s = 7'h30;
      default: s = 7'h38;
    endcase
    return s;
  endfunction

  // One bit per digit: set where the digit is a leading zero to blank.
  function automatic logic [DIGITS-1:0] lead_blank(input logic [VAL_W-1:0] v,
                                                    input logic en);
    logic [DIGITS-1:0] m;
    logic still_zero;
    m = '0;
    still_zero = en;
    for (int i = DIGITS - 1; i > 0; i--) begin
      still_zero = still_zero && (v[i*NIB_W +: NIB_W] == '0);
      m[i] = still_zero;
    end
    return m;
  endfunction
endpackage

// File: rtl/hexscan_divider.sv
module hexscan_divider #(
  parameter int CNT_W = 24,
  parameter int TAP   = 17
) (
  input  logic clk,
  input  logic clr,
  output logic step
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // step is high in the cycle just before bit TAP rises.
  generate
    if (TAP == 0) begin : g_tap0
      assign step = ~cnt[0];
    end else begin : g_tapn
      assign step = ~cnt[TAP] & (&cnt[TAP-1:0]);
    end
  endgenerate

  a_r2_tap_rises: assert property (@(posedge clk) disable iff (clr)
    step |=> cnt[TAP]);
  a_r2_counter_wraps: assert property (@(posedge clk) disable iff (clr)
    (cnt == '1) |=> (cnt == '0));
endmodule

// File: rtl/hexscan_scan.sv
module hexscan_scan
  import hexscan_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)       idx <= '0;
    else if (step) idx <= idx + 1'b1;
  end

  a_r2_advance: assert property (@(posedge clk) disable iff (clr)
    step |=> (idx == $past(idx) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (clr)
    !step |=> $stable(idx));
endmodule

// File: rtl/hexscan_digit.sv
module hexscan_digit
  import hexscan_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [VAL_W-1:0]  value,
  input  logic [DIGITS-1:0] blank_mask,
  output logic [SEG_W-1:0]  seg_n,
  output logic [DIGITS-1:0] an_n
);
  logic [NIB_W-1:0] nib;

  assign nib = value[idx*NIB_W +: NIB_W];

  always_comb begin
    an_n = '1;
    an_n[idx] = 1'b0;
    seg_n = blank_mask[idx] ? SEG_DARK : nib_to_seg_n(nib);
  end
endmodule

// File: rtl/hexscan_top.sv
module hexscan_top
  import hexscan_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int TAP   = 17
) (
  input  logic             clk_master,
  input  logic             clr,
  input  logic [VAL_W-1:0] value,
  input  logic             blank_en,
  output logic [SEG_W-1:0] seg_n,
  output logic [DIGITS-1:0] an_n,
  output logic             dp_n
);
  logic             scan_step;
  logic [IDX_W-1:0] digit_idx;
  logic [DIGITS-1:0] blank_mask;

  hexscan_divider #(.CNT_W(CNT_W), .TAP(TAP)) u_div (
    .clk(clk_master), .clr(clr), .step(scan_step));

  hexscan_scan u_scan (
    .clk(clk_master), .clr(clr), .step(scan_step), .idx(digit_idx));

  assign blank_mask = lead_blank(value, blank_en);

  hexscan_digit u_digit (
    .idx(digit_idx), .value(value), .blank_mask(blank_mask),
    .seg_n(seg_n), .an_n(an_n));

  assign dp_n = 1'b1;

  a_r3_one_anode: assert property (@(posedge clk_master) disable iff (clr)
    $countones(~an_n) == 1);
  a_r6_dark_needs_enable: assert property (@(posedge clk_master) disable iff (clr)
    (seg_n == SEG_DARK) |-> blank_en);
  a_r8_digit0_lit: assert property (@(posedge clk_master) disable iff (clr)
    !an_n[0] |-> (seg_n != SEG_DARK));
endmodule

// File: tb/tb_hexscan_top.sv
module tb_hexscan_top;
  localparam int TAP = 3;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [15:0] value = 16'h0000;
  logic        blank_en = 1'b0;
  logic [6:0]  seg_n;
  logic [3:0]  an_n;
  logic        dp_n;

  int errors = 0;
  int checks = 0;
  int k = 0;
  bit done = 0;

  hexscan_top #(.CNT_W(24), .TAP(TAP)) dut (
    .clk_master(clk), .clr(clr), .value(value), .blank_en(blank_en),
    .seg_n(seg_n), .an_n(an_n), .dp_n(dp_n));

  always #5 clk = ~clk;

  always @(posedge clk or posedge clr) begin
    if (clr) k <= 0;
    else     k <= k + 1;
  end

  function automatic logic [6:0] shape_hi(input logic [3:0] n);
    case (n)
      4'h0: return 7'h7E; 4'h1: return 7'h30; 4'h2: return 7'h6D; 4'h3: return 7'h79;
      4'h4: return 7'h33; 4'h5: return 7'h5B; 4'h6: return 7'h5F; 4'h7: return 7'h70;
      4'h8: return 7'h7F; 4'h9: return 7'h7B; 4'hA: return 7'h77; 4'hB: return 7'h1F;
      4'hC: return 7'h4E; 4'hD: return 7'h3D; 4'hE: return 7'h4F; default: return 7'h47;
    endcase
  endfunction

  function automatic int top_nonzero(input logic [15:0] v);
    int hi = 0;
    for (int i = 0; i < 4; i++) if (v[4*i +: 4] != 4'h0) hi = i;
    return hi;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_now(input int d);
    logic [6:0] es;
    if (blank_en && d > top_nonzero(value)) es = 7'h7F;
    else es = ~shape_hi(value[4*d +: 4]);
    chk(an_n == ~(4'b0001 << d), "R2/R3 anode", an_n, ~(4'b0001 << d));
    chk(seg_n == es, "R4/R6/R7/R8 segments", seg_n, es);
    chk(dp_n == 1'b1, "R5 dp", dp_n, 1);
  endtask

  task automatic run_pattern(input logic [15:0] v, input bit en, input int cycles);
    @(negedge clk);
    value = v;
    blank_en = en;
    #1;
    for (int c = 0; c < cycles; c++) begin
      check_now(((k + (1 << TAP)) >> (TAP + 1)) & 3);
      @(negedge clk);
    end
  endtask

  task automatic test_reset;
    value = 16'h12A5;
    #23;
    chk(an_n == 4'b1110, "R1 anode in clear", an_n, 4'b1110);
    chk(seg_n == ~shape_hi(4'h5), "R1 seg in clear", seg_n, ~shape_hi(4'h5));
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic test_async_clear;
    @(negedge clk);
    @(negedge clk);
    #2 clr = 1'b1;
    #1;
    chk(an_n == 4'b1110, "R1 async clear", an_n, 4'b1110);
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    test_reset;
    run_pattern(16'h1234, 1'b0, 80);   // R2 R3 R4
    run_pattern(16'hABCD, 1'b0, 64);   // R4 letters
    run_pattern(16'hEF09, 1'b1, 64);   // R4, R7 no leading zero
    run_pattern(16'h0040, 1'b0, 64);   // R6 zeros shown
    run_pattern(16'h0040, 1'b1, 64);   // R7 leading zeros dark
    run_pattern(16'h0807, 1'b1, 64);   // R7 interior zero shown
    run_pattern(16'h0000, 1'b1, 64);   // R8 single zero
    test_async_clear;                  // R1
    run_pattern(16'h5A60, 1'b1, 48);   // R2 restart after clear
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule